// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a bus-clocked watchdog timer that software controls through a single 32-bit register. The timer cannot be started, stopped or refreshed by one stray write. Each action has its own 2-bit command field. The action happens only when software writes an arm code into that field and then a fire code into the same field. A completed sequence on the enable field flips the timer between running and stopped. A completed sequence on the reload field restarts the countdown.

The low 24 bits of every write are kept as the reload value. The countdown length is that value shifted left by 8, counted in bus-clock cycles. When the countdown runs out, the block drives a one-cycle reset request and starts the next period. An optional early-warning pulse fires when the count reaches a threshold that the surrounding logic supplies. A read of the register returns the running state in bit 31 and the stored reload value in bits 23:0.

Top module: `keyed_wdog`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0 and `tmo_rst` and `warn_irq` are low.
- R2: Every write stores `wr_data[23:0]` as the reload value. `rd_data` shows bit 31 = running, bits 23:0 = stored reload value, and all other bits 0.
- R3: The enable field is bits 25:24. A write of code 1 followed by a later write of code 2 in that field toggles the running state. Starting the timer loads the counter with (value of that write) << 8.
- R4: Key rules for each field apply to the two fields independently. Code 1 arms the field. Code 2 fires only if the field is armed, and then disarms it. Code 2 on an unarmed field is ignored. Code 3 disarms the field. Code 0 leaves the armed state unchanged.
- R5: While running, the counter decrements once per clock. A counter loaded with C at clock edge E makes `tmo_rst` high for exactly one cycle after edge E+C+1. The counter then reloads C from the stored value, so further pulses follow every C+1 cycles.
- R6: The reload field is bits 27:26. A completed 1-then-2 sequence while running reloads the counter from that write's value << 8. The same sequence while stopped has no effect.
- R7: With a nonzero `warn_thresh` T, `warn_irq` pulses for one cycle after the edge that follows the counter holding T (edge E+C-T+1 after a load at edge E). A `warn_thresh` of 0 disables the warning.
- R8: Once stopped, the block produces no `tmo_rst` or `warn_irq` pulses and bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data (command fields and reload value) |
| warn_thresh | input | 32 | Counter value that raises the early warning; 0 disables it |
| rd_data | output | 32 | Register read value |
| tmo_rst | output | 1 | One-cycle timeout reset request |
| warn_irq | output | 1 | One-cycle early-warning pulse |

## Verification
A wrong armed state in either field is hidden until software finishes a sequence. It shows at the ports as bit 31 of `rd_data` failing to change, or changing when it should not, on the cycle right after the fire write. A wrong counter value shows only at the next expiry or warning, up to C+1 cycles later. For that reason the bench predicts the exact edge of every `tmo_rst` and `warn_irq` pulse and flags any pulse that arrives early, late or without being expected.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 32-bit control register with fixed command-field positions.
package kwd_pkg;
    localparam int REG_W   = 32;
    localparam int CMD_W   = 2;
    localparam int EN_LSB  = 24;
    localparam int RLD_LSB = 26;
    localparam int RUN_BIT = 31;
    localparam int N_FIELD = 2;

    typedef enum logic [CMD_W-1:0] {
        KEY_HOLD  = 2'd0,
        KEY_ARM   = 2'd1,
        KEY_FIRE  = 2'd2,
        KEY_ABORT = 2'd3
    } key_code_e;
endpackage

// File: rtl/kwd_key_step.sv
// Two-step key tracker for one command field.
// Arms on code 1; fires (one cycle, combinational) on code 2 when armed;
// code 3 disarms; code 0 keeps the state. Assumes one write per cycle.
module kwd_key_step
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] code,
    output logic             fire,
    output logic             armed
);
    key_code_e kc;
    assign kc = key_code_e'(code);

    // Fire only when the armed step is followed by the fire code.
    assign fire = wr_en && armed && (kc == KEY_FIRE);

    // Track the armed step of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr_en) begin
            case (kc)
                KEY_ARM:   armed <= 1'b1;
                KEY_FIRE:  armed <= 1'b0;
                KEY_ABORT: armed <= 1'b0;
                default:   armed <= armed;
            endcase
        end
    end
endmodule

// File: rtl/kwd_countdown.sv
// Countdown core: run state, down counter, expiry pulse and warning pulse.
// Assumes commands arrive as single-cycle strobes. The load value is the
// upper LOAD_W bits of a CNT_W-bit count.
module kwd_countdown #(
    parameter int CNT_W  = 32,
    parameter int LOAD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_toggle,
    input  logic              reload_cmd,
    input  logic [LOAD_W-1:0] load_val,
    input  logic [CNT_W-1:0]  thresh,
    output logic              running,
    output logic              tmo,
    output logic              warn
);
    localparam int SHIFT = CNT_W - LOAD_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] full;

    // Expand the stored upper bits into a full cycle count.
    assign full = CNT_W'(load_val) << SHIFT;

    // Run state, counting, expiry reload and pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            tmo     <= 1'b0;
            warn    <= 1'b0;
        end else begin
            tmo  <= 1'b0;
            warn <= 1'b0;
            if (en_toggle && !running) begin
                running <= 1'b1;
                cnt     <= full;
            end else if (en_toggle) begin
                running <= 1'b0;
            end else if (running) begin
                if (reload_cmd) begin
                    cnt <= full;
                end else if (cnt == '0) begin
                    cnt <= full;
                    tmo <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                    if ((thresh != '0) && (cnt == thresh)) begin
                        warn <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
// Top of the keyed watchdog: register decode, per-field key trackers,
// stored reload value and countdown core. Assumes wr_data is valid
// whenever wr_en is high.
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LOAD_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CNT_W-1:0] warn_thresh,
    output logic [REG_W-1:0] rd_data,
    output logic             tmo_rst,
    output logic             warn_irq
);
    logic [N_FIELD-1:0] fire_v;
    logic [N_FIELD-1:0] armed_v;
    logic [LOAD_W-1:0]  reload_q;
    logic [LOAD_W-1:0]  load_now;
    logic               running;
    logic               en_armed;

    // One key tracker per command field; index 0 = enable, 1 = reload.
    for (genvar g = 0; g < N_FIELD; g++) begin : g_key
        localparam int LSB = (g == 0) ? EN_LSB : RLD_LSB;
        kwd_key_step u_key (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .code  (wr_data[LSB +: CMD_W]),
            .fire  (fire_v[g]),
            .armed (armed_v[g])
        );
    end

    assign en_armed = armed_v[0];

    // Latch the reload value on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_en) begin
            reload_q <= wr_data[LOAD_W-1:0];
        end
    end

    // A write's own value applies to commands it completes.
    assign load_now = wr_en ? wr_data[LOAD_W-1:0] : reload_q;

    kwd_countdown #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_toggle  (fire_v[0]),
        .reload_cmd (fire_v[1]),
        .load_val   (load_now),
        .thresh     (warn_thresh),
        .running    (running),
        .tmo        (tmo_rst),
        .warn       (warn_irq)
    );

    // Assemble the read view of the register.
    always_comb begin
        rd_data               = '0;
        rd_data[RUN_BIT]      = running;
        rd_data[LOAD_W-1:0]   = reload_q;
    end
endmodule

// File: rtl/keyed_wdog_chk.sv
// Property checker for keyed_wdog, attached through bind.
module keyed_wdog_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       en_code,
    input logic             running,
    input logic             en_armed,
    input logic             tmo,
    input logic             warn,
    input logic [CNT_W-1:0] warn_thresh
);
    // R5
    tmo_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> $past(running));

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> (!tmo && !warn));

    // R3
    run_change_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running != $past(running)) |-> $past(wr_en));

    // R4
    arm_on_code1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_armed) |-> $past(wr_en && (en_code == 2'd1)));

    // R7
    warn_nonzero_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> ($past(warn_thresh) != '0));

    // R7
    warn_tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(warn && tmo));
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .en_code     (wr_data[25:24]),
    .running     (running),
    .en_armed    (en_armed),
    .tmo         (tmo_rst),
    .warn        (warn_irq),
    .warn_thresh (warn_thresh)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] warn_thresh = 32'd100;
    logic [31:0] rd_data;
    logic        tmo_rst;
    logic        warn_irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int last_edge = 0;
    bit done = 1'b0;
    int tq[$];
    int wq[$];

    keyed_wdog dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .warn_thresh(warn_thresh), .rd_data(rd_data),
        .tmo_rst(tmo_rst), .warn_irq(warn_irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one register write; last_edge = capturing clock edge index.
    task automatic wr(input logic [1:0] rl, input logic [1:0] en, input logic [23:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {4'b0, rl, en, v};
        @(negedge clk);
        wr_en   = 1'b0;
        last_edge = cyc;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: pop expected pulse cycles and compare.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tmo_rst) begin
                if (tq.size() == 0) chk(1'b0, "R8 unexpected tmo_rst", cyc, 0);
                else begin
                    int e;
                    e = tq.pop_front();
                    chk(cyc == e, "R5 tmo_rst cycle", cyc, e);
                end
            end
            if (warn_irq) begin
                if (wq.size() == 0) chk(1'b0, "R7 unexpected warn_irq", cyc, 0);
                else begin
                    int e;
                    e = wq.pop_front();
                    chk(cyc == e, "R7 warn_irq cycle", cyc, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(rd_data == 32'h0, "R1 rd_data", rd_data, 0);
        chk(!tmo_rst && !warn_irq, "R1 outputs", {tmo_rst, warn_irq}, 0);
        rst_n = 1'b1;

        // R2 value latched, fields zero
        wr(2'd0, 2'd0, 24'h000001);
        chk(rd_data == 32'h1, "R2 rd_data", rd_data, 32'h1);

        // R4 fire without arm ignored
        wr(2'd0, 2'd2, 24'h1);
        chk(rd_data[31] == 1'b0, "R4 unarmed fire", rd_data[31], 0);

        // R4 abort with code 3
        wr(2'd0, 2'd1, 24'h1);
        wr(2'd0, 2'd3, 24'h1);
        wr(2'd0, 2'd2, 24'h1);
        chk(rd_data[31] == 1'b0, "R4 abort", rd_data[31], 0);

        // R3/R4 arm, code 0 keeps arm, then fire -> start with C=256
        wr(2'd0, 2'd1, 24'h1);
        wr(2'd1, 2'd0, 24'h1);
        wr(2'd0, 2'd2, 24'h1);
        e0 = last_edge;
        tq.push_back(e0 + 257); tq.push_back(e0 + 514);
        wq.push_back(e0 + 157); wq.push_back(e0 + 414);
        chk(rd_data == 32'h8000_0001, "R3 running", rd_data, 32'h8000_0001);
        wait_to(e0 + 530);
        chk(tq.size() == 0, "R5 two periods seen", tq.size(), 0);
        chk(wq.size() == 0, "R7 two warnings seen", wq.size(), 0);

        // R6 reload while running
        wr(2'd1, 2'd0, 24'h1);
        wr(2'd2, 2'd0, 24'h1);
        e0 = last_edge;
        tq.push_back(e0 + 257);
        wq.push_back(e0 + 157);
        wait_to(e0 + 260);
        chk(tq.size() == 0, "R6 reload timing tmo", tq.size(), 0);
        chk(wq.size() == 0, "R6 reload timing warn", wq.size(), 0);

        // R8 disable
        wr(2'd0, 2'd1, 24'h1);
        wr(2'd0, 2'd2, 24'h1);
        chk(rd_data[31] == 1'b0, "R8 stopped", rd_data[31], 0);
        repeat (700) @(negedge clk);
        chk(rd_data[31] == 1'b0, "R8 still stopped", rd_data[31], 0);

        // R6 reload while stopped has no effect
        wr(2'd1, 2'd0, 24'h1);
        wr(2'd2, 2'd0, 24'h1);
        chk(rd_data[31] == 1'b0, "R6 reload when stopped", rd_data[31], 0);
        repeat (300) @(negedge clk);

        // R7 threshold 0 disables warning; C = 512
        warn_thresh = 32'd0;
        wr(2'd0, 2'd1, 24'h2);
        wr(2'd0, 2'd2, 24'h2);
        e0 = last_edge;
        tq.push_back(e0 + 513); tq.push_back(e0 + 1026);
        chk(rd_data == 32'h8000_0002, "R2 rd_data running", rd_data, 32'h8000_0002);
        wait_to(e0 + 1030);
        chk(tq.size() == 0, "R5 periods with C=512", tq.size(), 0);

        wr(2'd0, 2'd1, 24'h2);
        wr(2'd0, 2'd2, 24'h2);
        chk(rd_data[31] == 1'b0, "R3 toggle off", rd_data[31], 0);
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule